// File: doc/BRIEF.md
# Multiplexed-Bus Register Target

This block is a target on a 16-line multiplexed address/data bus with active-low address-latch, chip-select and byte-high-enable strobes and a direction line. It captures the address at the end of the address phase, decodes only the low 10 address bits, and splits that space into three regions: a bank of eight 16-bit registers, a reserved range, and an expansion window for 8-bit peripherals. For the expansion window it raises a select line and leaves the bus lines to the peripheral.

The register bank holds a fixed identity word, a control word made of a read-only revision, a contrast value and eight enable bits, and the output-data, direction and live-input registers of two 16-bit general-purpose ports. Port pins are reported as a drive value plus a per-bit output enable. Bus pins are assumed to be synchronous to `clk`. The bus lines are split into an input vector, an output vector and one output enable, and the pad ring combines them into the shared lines.

Top module: `mbt_target`

## Requirements
- R1: After reset, `ad_oe`, `exp_sel`, both port output-enable vectors, both port data vectors, `ctrl_en` and `contrast` are all zero.
- R2: Offset 0x0 reads as the `BOARD_ID` parameter (default 0x8100), and writes to it change nothing.
- R3: Offset 0x2 reads as {ctrl_en[7:0], contrast[3:0], revision[3:0]}. The revision is the `REVISION` parameter (default 0x3). A write loads bits 15:8 into `ctrl_en` and bits 7:4 into `contrast`, and its bits 3:0 are ignored.
- R4: Offsets 0x4 and 0x6 are the output-data registers of port A and port B. They drive `pa_out` and `pb_out` and read back what was written.
- R5: Offsets 0x8 and 0xA are the direction registers of port A and port B. Bit i of `pa_oe`/`pb_oe` equals bit i of the matching direction register, and the registers read back.
- R6: Offsets 0xC and 0xE read the present levels of `pa_in` and `pb_in`. Writes to them change no register.
- R7: Address bits 15:10 are ignored, so 0x0404 aliases 0x004 and 0xFC0C aliases 0x00C.
- R8: Offsets 0x10 to 0xFF are reserved. A read drives 0 with `ad_oe` high, a write changes no register, and `exp_sel` stays low.
- R9: Offsets 0x100 to 0x3FF form the expansion window. `exp_sel` is high while `cs_n` is low only for an 8-bit cycle (`bhe_n` high). The block never drives the lines there, and a write there changes no register.
- R10: A register write takes effect only for a 16-bit cycle (`bhe_n` low) at an even address. Other writes are ignored.
- R11: `ad_oe` is high only while `cs_n` is low with `dir_wr` low (read), and never at the same time as `exp_sel`.
- R12: The address is the value on `ad_i` in the cycle in which `ale_n` is first seen high. A write commits the value on `ad_i` in the cycle in which `cs_n` is first seen high, when `dir_wr` is high (write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, bus pins synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| ale_n | input | 1 | Address latch strobe, active low |
| cs_n | input | 1 | Chip select strobe, active low |
| dir_wr | input | 1 | Cycle direction: 1 write, 0 read |
| bhe_n | input | 1 | Byte-high enable, low for a 16-bit cycle |
| ad_i | input | 16 | Address/data lines as seen at the pads |
| ad_o | output | 16 | Read data driven onto the lines |
| ad_oe | output | 1 | Enable for driving `ad_o` onto the lines |
| pa_in | input | 16 | Port A pin levels |
| pb_in | input | 16 | Port B pin levels |
| pa_out | output | 16 | Port A drive values |
| pa_oe | output | 16 | Port A per-bit output enables |
| pb_out | output | 16 | Port B drive values |
| pb_oe | output | 16 | Port B per-bit output enables |
| ctrl_en | output | 8 | Individual control enables |
| contrast | output | 4 | Contrast setting |
| exp_sel | output | 1 | Expansion window select |

## Verification
A mis-captured address register shows on the very read that follows, as a wrong word or a wrong choice between driving the lines and raising `exp_sel`. For this reason the bench puts window-range junk on the lines during the data phase of every read. A write strobe that fires at the wrong time or to the wrong index shows on the port or control pins one clock after the rising edge of `cs_n`, and a later read of an unrelated register exposes it. Dropped qualifiers (cycle width, alignment, region) show as a register that changes after a write that should have been ignored.

// File: rtl/mbt_pkg.sv
// Shared types for the multiplexed-bus register target.
// Assumes a register bank of 2**IDX_W halfword registers at the bottom of the space.
package mbt_pkg;
    localparam int IDX_W    = 3;
    localparam int REG_SPAN = 2 ** (IDX_W + 1);

    typedef enum logic [1:0] {
        RGN_REG = 2'd0,
        RGN_RSV = 2'd1,
        RGN_WIN = 2'd2
    } region_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_ID    = 3'd0,
        IDX_CTRL  = 3'd1,
        IDX_DAT_A = 3'd2,
        IDX_DAT_B = 3'd3,
        IDX_DIR_A = 3'd4,
        IDX_DIR_B = 3'd5,
        IDX_PIN_A = 3'd6,
        IDX_PIN_B = 3'd7
    } reg_idx_t;
endpackage

// File: rtl/mbt_addr_latch.sv
// Address capture and region decode.
// Samples the strobes each clock. It latches the address when ale_n is first seen
// high and pulses wr_stb when cs_n is first seen high during a write cycle.
// Assumes the address is still held on the lines in the cycle after ale_n rises.
module mbt_addr_latch
    import mbt_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WIN_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_n,
    input  logic              cs_n,
    input  logic              dir_wr,
    input  logic [ADDR_W-1:0] addr_in,
    output region_t           region,
    output logic [IDX_W-1:0]  idx,
    output logic              aligned,
    output logic              wr_stb
);
    localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(REG_SPAN);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BASE);

    logic              ale_q;
    logic              cs_q;
    logic [ADDR_W-1:0] addr_q;

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b1;
            cs_q  <= 1'b1;
        end else begin
            ale_q <= ale_n;
            cs_q  <= cs_n;
        end
    end

    // Capture the address at the rising edge of the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (ale_n && !ale_q)
            addr_q <= addr_in;
    end

    // Classify the held address into one of the three regions.
    always_comb begin
        if (addr_q < REG_LIM)
            region = RGN_REG;
        else if (addr_q < WIN_LIM)
            region = RGN_RSV;
        else
            region = RGN_WIN;
    end

    assign idx     = addr_q[IDX_W:1];
    assign aligned = !addr_q[0];
    assign wr_stb  = cs_n && !cs_q && dir_wr;

    // R12: the held address moves only at a latch-strobe rising edge
    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_n && !ale_q) |=> $stable(addr_q));
endmodule

// File: rtl/mbt_regbank.sv
// Writable register storage: control word, contrast and the two port register pairs.
// Assumes wr_en has already been qualified by region, cycle width and alignment.
module mbt_regbank
    import mbt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CTRL_W  = 8,
    parameter int CONTR_W = 4,
    parameter int REV_W   = 4,
    parameter int PORTS   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [PORTS-1:0][DATA_W-1:0] dat,
    output logic [PORTS-1:0][DATA_W-1:0] dir,
    output logic [CTRL_W-1:0]            ctrl,
    output logic [CONTR_W-1:0]           contr
);
    localparam int CTL_LO = REV_W;

    // Load the control and contrast fields. The revision slice of wdata is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            contr <= '0;
        end else if (wr_en && idx == IDX_CTRL) begin
            {ctrl, contr} <= wdata[DATA_W-1:CTL_LO];
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // Output-data register of port p.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dat[p] <= '0;
            else if (wr_en && idx == IDX_W'(int'(IDX_DAT_A) + p))
                dat[p] <= wdata;
        end

        // Direction register of port p.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dir[p] <= '0;
            else if (wr_en && idx == IDX_W'(int'(IDX_DIR_A) + p))
                dir[p] <= wdata;
        end

        // R10: no register of port p changes without a qualified write
        a_r10_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> ($stable(dat[p]) && $stable(dir[p])));
    end

    // R10: control bits change only on a qualified write
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctrl) && $stable(contr)));
endmodule

// File: rtl/mbt_rdmux.sv
// Read-data selection by region and register index.
// Assumes the window region is never driven by this block, so it returns zero there.
module mbt_rdmux
    import mbt_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          CTRL_W   = 8,
    parameter int          CONTR_W  = 4,
    parameter int          REV_W    = 4,
    parameter int          PORTS    = 2,
    parameter logic [15:0] BOARD_ID = 16'h8100,
    parameter logic [3:0]  REVISION = 4'h3
) (
    input  region_t                      region,
    input  logic [IDX_W-1:0]             idx,
    input  logic [PORTS-1:0][DATA_W-1:0] dat,
    input  logic [PORTS-1:0][DATA_W-1:0] dir,
    input  logic [PORTS-1:0][DATA_W-1:0] pins,
    input  logic [CTRL_W-1:0]            ctrl,
    input  logic [CONTR_W-1:0]           contr,
    output logic [DATA_W-1:0]            rd_data
);
    // Pick the word for the held address. Reserved and window regions read as zero.
    always_comb begin
        rd_data = '0;
        if (region == RGN_REG) begin
            case (idx)
                IDX_ID:    rd_data = DATA_W'(BOARD_ID);
                IDX_CTRL:  rd_data = {ctrl, contr, REV_W'(REVISION)};
                IDX_DAT_A: rd_data = dat[0];
                IDX_DAT_B: rd_data = dat[1];
                IDX_DIR_A: rd_data = dir[0];
                IDX_DIR_B: rd_data = dir[1];
                IDX_PIN_A: rd_data = pins[0];
                default:   rd_data = pins[1];
            endcase
        end
    end
endmodule

// File: rtl/mbt_target.sv
// Top of the multiplexed-bus register target.
// Joins the address latch, the register bank and the read mux, and generates the
// line-drive enable and the expansion select.
// Assumes all bus pins are synchronous to clk and that the pads merge ad_o/ad_oe.
module mbt_target
    import mbt_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 10,
    parameter int          WIN_BASE = 256,
    parameter int          CTRL_W   = 8,
    parameter int          CONTR_W  = 4,
    parameter int          REV_W    = 4,
    parameter logic [15:0] BOARD_ID = 16'h8100,
    parameter logic [3:0]  REVISION = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_n,
    input  logic              cs_n,
    input  logic              dir_wr,
    input  logic              bhe_n,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    output logic [CTRL_W-1:0] ctrl_en,
    output logic [CONTR_W-1:0] contrast,
    output logic              exp_sel
);
    localparam int PORTS = 2;

    region_t                      region;
    logic [IDX_W-1:0]             idx;
    logic                         aligned;
    logic                         wr_stb;
    logic                         wr_en;
    logic [PORTS-1:0][DATA_W-1:0] dat;
    logic [PORTS-1:0][DATA_W-1:0] dir;
    logic [PORTS-1:0][DATA_W-1:0] pins;

    mbt_addr_latch #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale_n  (ale_n),
        .cs_n   (cs_n),
        .dir_wr (dir_wr),
        .addr_in(ad_i[ADDR_W-1:0]),
        .region (region),
        .idx    (idx),
        .aligned(aligned),
        .wr_stb (wr_stb)
    );

    // Qualify the write: register region, 16-bit cycle, even address.
    assign wr_en = wr_stb && (region == RGN_REG) && !bhe_n && aligned;

    mbt_regbank #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W),
        .CONTR_W(CONTR_W),
        .REV_W  (REV_W),
        .PORTS  (PORTS)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .idx  (idx),
        .wdata(ad_i),
        .dat  (dat),
        .dir  (dir),
        .ctrl (ctrl_en),
        .contr(contrast)
    );

    assign pins = {pb_in, pa_in};

    mbt_rdmux #(
        .DATA_W  (DATA_W),
        .CTRL_W  (CTRL_W),
        .CONTR_W (CONTR_W),
        .REV_W   (REV_W),
        .PORTS   (PORTS),
        .BOARD_ID(BOARD_ID),
        .REVISION(REVISION)
    ) u_rdmux (
        .region (region),
        .idx    (idx),
        .dat    (dat),
        .dir    (dir),
        .pins   (pins),
        .ctrl   (ctrl_en),
        .contr  (contrast),
        .rd_data(ad_o)
    );

    // Drive the lines on reads outside the window, select the window on 8-bit cycles.
    assign ad_oe   = !cs_n && !dir_wr && (region != RGN_WIN);
    assign exp_sel = !cs_n && bhe_n && (region == RGN_WIN);

    assign pa_out = dat[0];
    assign pb_out = dat[1];
    assign pa_oe  = dir[0];
    assign pb_oe  = dir[1];

    // R11: the block and a window peripheral never drive together
    a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && exp_sel));
    // R11: lines are driven only during a selected read
    a_r11_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!cs_n && !dir_wr));
    // R2: an identity read always shows the fixed word
    a_r2_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && region == RGN_REG && idx == IDX_ID) |-> (ad_o == DATA_W'(BOARD_ID)));
endmodule

// File: tb/mbt_target_tb.sv
module mbt_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        dir_wr = 1'b0;
    logic        bhe_n = 1'b0;
    logic [15:0] ad_i = 16'h0;
    logic [15:0] pa_in = 16'h0;
    logic [15:0] pb_in = 16'h0;
    logic [15:0] ad_o, pa_out, pa_oe, pb_out, pb_oe;
    logic        ad_oe, exp_sel;
    logic [7:0]  ctrl_en;
    logic [3:0]  contrast;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [15:0] val;
        logic        oe;
        logic        sel;
    } exp_t;
    exp_t exp_q[$];
    logic sample_now = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mbt_target u_dut (
        .clk(clk), .rst_n(rst_n), .ale_n(ale_n), .cs_n(cs_n), .dir_wr(dir_wr),
        .bhe_n(bhe_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .pa_in(pa_in), .pb_in(pb_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .ctrl_en(ctrl_en), .contrast(contrast),
        .exp_sel(exp_sel)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per read and compares it with the line outputs.
    initial begin
        forever begin
            @(posedge clk);
            if (sample_now) begin
                @(negedge clk);
                #1;
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " oe"}, {15'h0, ad_oe}, {15'h0, e.oe});
                    chk({e.tag, " sel"}, {15'h0, exp_sel}, {15'h0, e.sel});
                    if (e.oe) chk({e.tag, " data"}, ad_o, e.val);
                end
            end
        end
    end

    // Common address phase.
    task automatic addr_phase(input logic wr, input logic [15:0] a, input logic bhe);
        @(negedge clk);
        ale_n = 1'b0; ad_i = a; dir_wr = wr; bhe_n = bhe;
        @(negedge clk);
        ale_n = 1'b1;
        @(negedge clk);
    endtask

    // Write with separate values before and at the chip-select rising edge.
    task automatic bus_wr2(input logic [15:0] a, input logic [15:0] d_early,
                           input logic [15:0] d_late, input logic bhe);
        addr_phase(1'b1, a, bhe);
        ad_i = d_early;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R11 no drive on write", {15'h0, ad_oe}, 16'h0);
        @(negedge clk);
        cs_n = 1'b1; ad_i = d_late;
        @(negedge clk);
        dir_wr = 1'b0; bhe_n = 1'b0;
        #1;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic bhe);
        bus_wr2(a, d, d, bhe);
    endtask

    // Read: the driver pushes the expectation and flags the monitor during chip select.
    task automatic bus_rd(input string tag, input logic [15:0] a, input logic bhe,
                          input logic [15:0] val, input logic oe, input logic sel);
        exp_t e;
        addr_phase(1'b0, a, bhe);
        ad_i = 16'h0114;  // window-range junk: a late capture would show
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        e.tag = tag; e.val = val; e.oe = oe; e.sel = sel;
        exp_q.push_back(e);
        sample_now = 1'b1;
        @(negedge clk);
        sample_now = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        bhe_n = 1'b0;
        #1;
        chk({tag, " idle no drive"}, {15'h0, ad_oe}, 16'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        #1;
        chk("R1 ad_oe", {15'h0, ad_oe}, 16'h0);
        chk("R1 pa_oe", pa_oe, 16'h0);
        chk("R1 pb_oe", pb_oe, 16'h0);
        chk("R1 pa_out", pa_out, 16'h0);
        chk("R1 pb_out", pb_out, 16'h0);
        chk("R1 ctrl", {8'h0, ctrl_en}, 16'h0);
        chk("R1 contrast", {12'h0, contrast}, 16'h0);
        chk("R1 exp_sel", {15'h0, exp_sel}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        bus_rd("R2 id", 16'h0000, 1'b0, 16'h8100, 1'b1, 1'b0);
        bus_wr(16'h0000, 16'h1234, 1'b0);
        bus_rd("R2 id after write", 16'h0000, 1'b0, 16'h8100, 1'b1, 1'b0);

        bus_wr(16'h0002, 16'hA5F7, 1'b0);
        chk("R3 ctrl pins", {8'h0, ctrl_en}, 16'h00A5);
        chk("R3 contrast pins", {12'h0, contrast}, 16'h000F);
        bus_rd("R3 ctrl read", 16'h0002, 1'b0, 16'hA5F3, 1'b1, 1'b0);

        bus_wr(16'h0004, 16'h1357, 1'b0);
        bus_wr(16'h0006, 16'h9BDF, 1'b0);
        chk("R4 pa_out", pa_out, 16'h1357);
        chk("R4 pb_out", pb_out, 16'h9BDF);
        bus_rd("R4 port A data", 16'h0004, 1'b0, 16'h1357, 1'b1, 1'b0);
        bus_rd("R4 port B data", 16'h0006, 1'b0, 16'h9BDF, 1'b1, 1'b0);

        bus_wr(16'h0008, 16'h00FF, 1'b0);
        bus_wr(16'h000A, 16'hF00F, 1'b0);
        chk("R5 pa_oe", pa_oe, 16'h00FF);
        chk("R5 pb_oe", pb_oe, 16'hF00F);
        bus_rd("R5 port A dir", 16'h0008, 1'b0, 16'h00FF, 1'b1, 1'b0);
        bus_rd("R5 port B dir", 16'h000A, 1'b0, 16'hF00F, 1'b1, 1'b0);

        pa_in = 16'hC3C3; pb_in = 16'h5A5A;
        bus_rd("R6 port A pins", 16'h000C, 1'b0, 16'hC3C3, 1'b1, 1'b0);
        bus_rd("R6 port B pins", 16'h000E, 1'b0, 16'h5A5A, 1'b1, 1'b0);
        bus_wr(16'h000C, 16'hFFFF, 1'b0);
        bus_wr(16'h000E, 16'hFFFF, 1'b0);
        chk("R6 write no effect pa_out", pa_out, 16'h1357);
        chk("R6 write no effect pb_oe", pb_oe, 16'hF00F);
        bus_rd("R6 pins after write", 16'h000C, 1'b0, 16'hC3C3, 1'b1, 1'b0);

        bus_wr(16'h0404, 16'h2468, 1'b0);
        chk("R7 alias write", pa_out, 16'h2468);
        bus_rd("R7 alias read", 16'hFC0C, 1'b0, 16'hC3C3, 1'b1, 1'b0);

        bus_wr(16'h0014, 16'hFFFF, 1'b0);
        bus_wr(16'h00F8, 16'hFFFF, 1'b0);
        chk("R8 reserved write pa_out", pa_out, 16'h2468);
        chk("R8 reserved write pa_oe", pa_oe, 16'h00FF);
        bus_rd("R8 reserved read", 16'h0014, 1'b0, 16'h0000, 1'b1, 1'b0);
        bus_rd("R8 reserved read 8-bit", 16'h00F8, 1'b1, 16'h0000, 1'b1, 1'b0);

        bus_rd("R9 window 8-bit", 16'h0120, 1'b1, 16'h0000, 1'b0, 1'b1);
        bus_rd("R9 window 16-bit", 16'h03FE, 1'b0, 16'h0000, 1'b0, 1'b0);
        bus_wr(16'h0104, 16'h0000, 1'b1);
        chk("R9 window write pa_out", pa_out, 16'h2468);

        bus_wr(16'h0004, 16'h0000, 1'b1);
        chk("R10 8-bit write ignored", pa_out, 16'h2468);
        bus_wr(16'h0005, 16'h0000, 1'b0);
        chk("R10 odd write ignored", pa_out, 16'h2468);
        bus_wr(16'h0003, 16'h0000, 1'b0);
        chk("R10 odd ctrl ignored", {8'h0, ctrl_en}, 16'h00A5);

        bus_wr2(16'h0006, 16'h1111, 16'h2222, 1'b0);
        chk("R12 commit at cs rise", pb_out, 16'h2222);
        bus_rd("R12 address held", 16'h0006, 1'b0, 16'h2222, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        chk("R12 queue drained", 16'(exp_q.size()), 16'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule